// File: doc/BRIEF.md
# Block Address Translation Array

This block translates large, aligned regions of effective address space straight to physical addresses, with no page-table walk. It holds a small set of entries, four by default, and compares all of them in parallel. Each entry covers a power-of-two region from 128 KB up to 256 MB. System software loads every entry through a simple write port, and hardware never fills one. A lookup gives an effective address, a privilege mode and an access direction. One cycle later the block returns a hit indication, the translated physical address and a protection-violation flag.

The instruction side and the data side each use their own instance of the same module. The region size is held per entry as an 11-bit size mask over effective-address bits 17 to 27. A mask bit of 1 removes that address bit from the compare and passes the effective-address bit through to the physical address. Bits 28 to 31 are always compared and always come from the entry. Bits 0 to 16 always pass through from the effective address.

Top module: `bat_array`

## Requirements
- R1: After reset, every entry is invalid in both privilege modes. `rsp_valid`, `rsp_hit`, `rsp_viol` and `rsp_paddr` are all 0. A lookup made before any write misses.
- R2: A write with `wr_en` high at a rising clock edge replaces entry `wr_idx` at that edge. A lookup sampled at the same edge still sees the old entry contents. The new contents apply from the next edge.
- R3: An entry matches when effective-address bits 31..28 equal its effective base bits 31..28. For each bit n from 17 to 27, bit n must also equal the base bit, except where size-mask bit (n-17) is 1. Size-mask value 0x000 gives a 128 KB region and 0x7FF gives a 256 MB region.
- R4: On a hit, the physical address is built from three parts. Bits 31..28 come from the entry's physical base. Each bit n from 17 to 27 comes from the effective address if size-mask bit (n-17) is 1, and from the physical base if it is 0. Bits 16..0 come from the effective address.
- R5: An entry takes part in a lookup only if its supervisor-enable bit is set when `lk_super`=1, or its user-enable bit is set when `lk_super`=0.
- R6: When several entries match, the lowest-numbered matching entry decides both the translation and the protection outcome.
- R7: A store lookup (`lk_write`=1) whose winning entry has its read-only bit set gives `rsp_viol`=1, `rsp_hit`=0 and `rsp_paddr`=0. A load lookup on the same entry hits normally.
- R8: When no entry matches, the response has `rsp_hit`=0, `rsp_viol`=0 and `rsp_paddr`=0.
- R9: The response fields appear at the clock edge after the one that samples `lk_valid`=1, and `rsp_valid` is then 1. If `lk_valid` was 0 at that edge, `rsp_valid`, `rsp_hit` and `rsp_viol` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 2 | Entry number to write |
| wr_eff_base | input | 15 | Effective base, address bits 31..17 |
| wr_phys_base | input | 15 | Physical base, address bits 31..17 |
| wr_size_mask | input | 11 | Size mask over address bits 27..17, 1 = don't-care |
| wr_sup_ok | input | 1 | Entry enabled in supervisor mode |
| wr_usr_ok | input | 1 | Entry enabled in user mode |
| wr_read_only | input | 1 | Entry forbids stores |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Effective address to translate |
| lk_super | input | 1 | 1 = supervisor, 0 = user |
| lk_write | input | 1 | 1 = store access, 0 = load or fetch |
| rsp_valid | output | 1 | Registered response valid |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_viol | output | 1 | Protection violation |
| rsp_paddr | output | 32 | Translated physical address, 0 unless hit |

## Verification
The assertions take the lookup inputs to be stable and defined whenever `lk_valid` is high. They also expect base addresses to be aligned to their region size, with base bits under mask ones written as 0. Size masks are taken to be contiguous runs of ones from bit 0, which is what makes each region a power-of-two size. Every entry the stimulus writes follows these rules. Lookups are driven on the falling clock edge and held for a whole cycle. The one deliberate same-edge overlap is a write and a lookup that meet at one edge, which tests the ordering in R2.

// File: rtl/bat_pkg.sv
package bat_pkg;
    localparam int ADDR_W  = 32;
    localparam int BLK_LSB = 17;
    localparam int MASK_W  = 11;
    localparam int BASE_W  = ADDR_W - BLK_LSB;
    localparam int FIX_W   = BASE_W - MASK_W;

    typedef struct packed {
        logic [BASE_W-1:0] eff_base;
        logic [BASE_W-1:0] phys_base;
        logic [MASK_W-1:0] size_mask;
        logic              sup_ok;
        logic              usr_ok;
        logic              read_only;
    } bat_entry_t;
endpackage

// File: rtl/bat_match.sv
module bat_match
    import bat_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic [N_ENT-1:0][BASE_W-1:0] eff_base,
    input  logic [N_ENT-1:0][MASK_W-1:0] size_mask,
    input  logic [N_ENT-1:0]             sup_ok,
    input  logic [N_ENT-1:0]             usr_ok,
    input  logic [BASE_W-1:0]            ea_hi,
    input  logic                         super_mode,
    output logic [N_ENT-1:0]             match
);
    genvar g;
    generate
        for (g = 0; g < N_ENT; g++) begin : g_ent
            logic [BASE_W-1:0] care;
            logic              mode_ok;
            assign care       = {{FIX_W{1'b1}}, ~size_mask[g]};
            assign mode_ok    = super_mode ? sup_ok[g] : usr_ok[g];
            assign match[g]   = mode_ok && (((ea_hi ^ eff_base[g]) & care) == '0);
        end
    endgenerate
endmodule

// File: rtl/bat_pick.sv
module bat_pick #(
    parameter int N_ENT = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0] match,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |match;
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/bat_merge.sv
module bat_merge
    import bat_pkg::*;
(
    input  logic [BASE_W-1:0] phys_base,
    input  logic [MASK_W-1:0] size_mask,
    input  logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] pa
);
    logic [MASK_W-1:0] mid;
    always_comb begin
        mid = (ea[BLK_LSB +: MASK_W] & size_mask)
            | (phys_base[MASK_W-1:0] & ~size_mask);
        pa  = {phys_base[BASE_W-1:MASK_W], mid, ea[BLK_LSB-1:0]};
    end
endmodule

// File: rtl/bat_array.sv
module bat_array
    import bat_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BASE_W-1:0] wr_eff_base,
    input  logic [BASE_W-1:0] wr_phys_base,
    input  logic [MASK_W-1:0] wr_size_mask,
    input  logic              wr_sup_ok,
    input  logic              wr_usr_ok,
    input  logic              wr_read_only,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_super,
    input  logic              lk_write,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_viol,
    output logic [ADDR_W-1:0] rsp_paddr
);
    typedef struct packed {
        bat_entry_t [N_ENT-1:0] ents;
        logic                   rsp_valid;
        logic                   rsp_hit;
        logic                   rsp_viol;
        logic [ADDR_W-1:0]      rsp_paddr;
    } state_t;

    state_t st_d, st_q;

    logic [N_ENT-1:0][BASE_W-1:0] eff_base_v;
    logic [N_ENT-1:0][MASK_W-1:0] mask_v;
    logic [N_ENT-1:0]             sup_v;
    logic [N_ENT-1:0]             usr_v;
    logic [N_ENT-1:0]             match;
    logic                         any_hit;
    logic [IDX_W-1:0]             win_idx;
    bat_entry_t                   win_ent;
    logic [ADDR_W-1:0]            merged_pa;

    genvar g;
    generate
        for (g = 0; g < N_ENT; g++) begin : g_split
            assign eff_base_v[g] = st_q.ents[g].eff_base;
            assign mask_v[g]     = st_q.ents[g].size_mask;
            assign sup_v[g]      = st_q.ents[g].sup_ok;
            assign usr_v[g]      = st_q.ents[g].usr_ok;
        end
    endgenerate

    bat_match #(.N_ENT(N_ENT)) match_i (
        .eff_base   (eff_base_v),
        .size_mask  (mask_v),
        .sup_ok     (sup_v),
        .usr_ok     (usr_v),
        .ea_hi      (lk_addr[ADDR_W-1:BLK_LSB]),
        .super_mode (lk_super),
        .match      (match)
    );

    bat_pick #(.N_ENT(N_ENT)) pick_i (
        .match (match),
        .any   (any_hit),
        .idx   (win_idx)
    );

    assign win_ent = st_q.ents[win_idx];

    bat_merge merge_i (
        .phys_base (win_ent.phys_base),
        .size_mask (win_ent.size_mask),
        .ea        (lk_addr),
        .pa        (merged_pa)
    );

    always_comb begin
        logic blocked;
        st_d    = st_q;
        blocked = any_hit && win_ent.read_only && lk_write;
        if (wr_en && (int'(wr_idx) < N_ENT)) begin
            st_d.ents[wr_idx].eff_base  = wr_eff_base;
            st_d.ents[wr_idx].phys_base = wr_phys_base;
            st_d.ents[wr_idx].size_mask = wr_size_mask;
            st_d.ents[wr_idx].sup_ok    = wr_sup_ok;
            st_d.ents[wr_idx].usr_ok    = wr_usr_ok;
            st_d.ents[wr_idx].read_only = wr_read_only;
        end
        st_d.rsp_valid = lk_valid;
        st_d.rsp_hit   = lk_valid && any_hit && !blocked;
        st_d.rsp_viol  = lk_valid && blocked;
        st_d.rsp_paddr = (lk_valid && any_hit && !blocked) ? merged_pa : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_viol  = st_q.rsp_viol;
    assign rsp_paddr = st_q.rsp_paddr;
endmodule

// File: rtl/bat_array_chk.sv
module bat_array_chk
    import bat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_viol,
    input logic [ADDR_W-1:0] rsp_paddr
);
    // R9: a request is answered on the next edge
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R9: no request, no response
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_viol));
    // R7: a blocked store never also reports a hit
    a_r7_hit_viol_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_viol));
    // R7 R8: no address is returned without a hit
    a_r8_pa_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_paddr == '0));
    // R4: the in-block offset passes through untouched
    a_r4_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit ||
            rsp_paddr[BLK_LSB-1:0] == $past(lk_addr[BLK_LSB-1:0])));
endmodule

bind bat_array bat_array_chk chk_i (.*);

// File: tb/bat_array_tb_top.sv
module bat_array_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [14:0] wr_eff_base = '0;
    logic [14:0] wr_phys_base = '0;
    logic [10:0] wr_size_mask = '0;
    logic        wr_sup_ok = 1'b0;
    logic        wr_usr_ok = 1'b0;
    logic        wr_read_only = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_super = 1'b0;
    logic        lk_write = 1'b0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic        rsp_viol;
    logic [31:0] rsp_paddr;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bat_array dut_i (.*);

    // {super, write, addr, exp_hit, exp_viol, exp_pa}
    localparam int NV = 16;
    localparam logic [67:0] VECS [0:NV-1] = '{
        {1'b1, 1'b0, 32'h1000_1234, 1'b1, 1'b0, 32'h8000_1234}, // R6 overlap, entry 0 wins
        {1'b1, 1'b0, 32'h1234_5678, 1'b1, 1'b0, 32'h9234_5678}, // R3 256 MB region
        {1'b1, 1'b0, 32'h1001_FFFF, 1'b1, 1'b0, 32'h8001_FFFF}, // R3 top of 128 KB
        {1'b1, 1'b0, 32'h1002_0000, 1'b1, 1'b0, 32'h9002_0000}, // R3 just past it
        {1'b1, 1'b0, 32'h1FFF_FFFF, 1'b1, 1'b0, 32'h9FFF_FFFF}, // R4 top of 256 MB
        {1'b1, 1'b0, 32'h2041_2345, 1'b1, 1'b0, 32'h4001_2345}, // R4 2 MB region
        {1'b1, 1'b0, 32'h2059_0000, 1'b1, 1'b0, 32'h4019_0000}, // R4 masked bits pass
        {1'b1, 1'b1, 32'h2041_2345, 1'b0, 1'b1, 32'h0000_0000}, // R7 store to read-only
        {1'b0, 1'b0, 32'h2041_2345, 1'b1, 1'b0, 32'hC041_2345}, // R5 user sees entry 3
        {1'b1, 1'b0, 32'h2060_0000, 1'b0, 1'b0, 32'h0000_0000}, // R5 R8 supervisor miss
        {1'b0, 1'b0, 32'h2060_0000, 1'b1, 1'b0, 32'hC060_0000}, // R5 user hit
        {1'b0, 1'b1, 32'h2060_0000, 1'b0, 1'b1, 32'h0000_0000}, // R7 user store
        {1'b0, 1'b0, 32'h2100_0000, 1'b0, 1'b0, 32'h0000_0000}, // R3 R8 outside 16 MB
        {1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000}, // R8 no entry
        {1'b1, 1'b1, 32'h1000_0004, 1'b1, 1'b0, 32'h8000_0004}, // R7 store to writable
        {1'b0, 1'b0, 32'h1234_5678, 1'b1, 1'b0, 32'h9234_5678}  // R5 user on shared entry
    };

    task automatic check_rsp(input string tag, input logic ev, input logic eh,
                             input logic ex, input logic [31:0] ep);
        n_vec++;
        if (rsp_valid !== ev || rsp_hit !== eh || rsp_viol !== ex || rsp_paddr !== ep) begin
            n_bad++;
            $display("FAIL %s: got v=%b hit=%b viol=%b pa=%h, expected v=%b hit=%b viol=%b pa=%h",
                     tag, rsp_valid, rsp_hit, rsp_viol, rsp_paddr, ev, eh, ex, ep);
        end
    endtask

    task automatic wr_entry(input logic [1:0] idx, input logic [31:0] ea, input logic [31:0] pa,
                            input logic [10:0] msk, input logic sv, input logic uv, input logic ro);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_eff_base = ea[31:17]; wr_phys_base = pa[31:17];
        wr_size_mask = msk; wr_sup_ok = sv; wr_usr_ok = uv; wr_read_only = ro;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic sup, input logic wr, input logic [31:0] a);
        @(negedge clk);
        lk_valid = 1'b1; lk_super = sup; lk_write = wr; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_rsp("R1 reset outputs", 1'b0, 1'b0, 1'b0, 32'h0);
        rst_n = 1'b1;
        lookup(1'b1, 1'b0, 32'h1000_1234);
        check_rsp("R1 empty array misses", 1'b1, 1'b0, 1'b0, 32'h0);

        wr_entry(2'd0, 32'h1000_0000, 32'h8000_0000, 11'h000, 1'b1, 1'b1, 1'b0);
        wr_entry(2'd1, 32'h1000_0000, 32'h9000_0000, 11'h7FF, 1'b1, 1'b1, 1'b0);
        wr_entry(2'd2, 32'h2040_0000, 32'h4000_0000, 11'h00F, 1'b1, 1'b0, 1'b1);
        wr_entry(2'd3, 32'h2000_0000, 32'hC000_0000, 11'h07F, 1'b0, 1'b1, 1'b1);

        for (int i = 0; i < NV; i++) begin
            lookup(VECS[i][67], VECS[i][66], VECS[i][65:34]);
            check_rsp($sformatf("R3/R4/R5/R6/R7/R8 vector %0d", i),
                      1'b1, VECS[i][33], VECS[i][32], VECS[i][31:0]);
        end

        // R9: no request gives a quiet response even for a hitting address
        @(negedge clk);
        lk_valid = 1'b0; lk_super = 1'b1; lk_addr = 32'h1000_1234;
        @(negedge clk);
        check_rsp("R9 idle lookup", 1'b0, 1'b0, 1'b0, 32'h0);

        // R2: write and lookup at the same edge, old entry still used
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'd0; wr_sup_ok = 1'b0; wr_usr_ok = 1'b0;
        lk_valid = 1'b1; lk_super = 1'b1; lk_write = 1'b0; lk_addr = 32'h1000_1234;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        check_rsp("R2 same-edge write unseen", 1'b1, 1'b1, 1'b0, 32'h8000_1234);
        lookup(1'b1, 1'b0, 32'h1000_1234);
        check_rsp("R2 R6 write seen next cycle", 1'b1, 1'b1, 1'b0, 32'h9000_1234);

        // R1: reset clears entries
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_rsp("R1 reset again", 1'b0, 1'b0, 1'b0, 32'h0);
        rst_n = 1'b1;
        lookup(1'b1, 1'b0, 32'h1234_5678);
        check_rsp("R1 entries cleared", 1'b1, 1'b0, 1'b0, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule